// File: doc/BRIEF.md
# Serial Word Loader for a Latched Serial-Input Driver

This block sits on the host side of a serial-input, latched output driver. It accepts one parallel word through a start/ready handshake. It shifts the word out one bit at a time on a data line and a shift clock, and then pulses a strobe that moves the shifted word into the driver's output latches. All of its outputs come from a fast system clock. Every interval the driver needs (data setup before the shift clock rises, shift clock high width, data hold after the clock, the gap before the strobe, and the strobe width) is a parameter, counted in system-clock cycles.

A parameter selects a variant for systems where the driver's latches are bypassed (strobe tied high). In that variant the controller holds the blanking output high for the whole load and the strobe. It releases blanking only after the strobe has fallen, so partly shifted data never reaches the driver outputs. The bit count is a parameter, so one controller can also serve a longer chain seen as a single wider word.

Top module: `serial_word_loader`

## Requirements
- R1: After reset the block is idle: `ready`=1, `busy`=0, and `ser_data`, `shift_clk`, `strobe` and `blank` are all 0.
- R2: A `start` seen high on a clock edge while `ready`=1 begins a frame. `busy`=1 and `ready`=0 hold from the next cycle until the frame ends, and `ready` is always the inverse of `busy`. A `start` while busy is ignored and does not change the word being sent.
- R3: Bits go out most significant first. During bit period k (k=0 first), `ser_data` equals `word_in[NBITS-1-k]` as captured at the accepted start. Outside the bit periods it is 0.
- R4: Each bit period begins with SETUP_CYC cycles of `shift_clk`=0 with the new data already on `ser_data`.
- R5: `shift_clk` then stays high for exactly HIGH_CYC cycles while `ser_data` does not change.
- R6: After `shift_clk` falls, `ser_data` holds the same bit for HOLD_CYC cycles with `shift_clk`=0 before the next bit period starts.
- R7: After the last hold period, `strobe` stays 0 for STB_GAP_CYC cycles before it rises. `strobe` and `shift_clk` are never high together.
- R8: `strobe` is high for exactly STB_CYC cycles. One further busy cycle with all strobe/clock/data outputs low follows, and then `ready` returns.
- R9: An interval parameter of 0 behaves as 1 cycle.
- R10: With BLANK_DURING_LOAD=1, `blank` is 1 from the first setup cycle through the last strobe cycle and 0 from the cycle after the strobe falls. With BLANK_DURING_LOAD=0, `blank` is always 0.
- R11: A downstream shift register that takes `ser_data` on each rising `shift_clk` and latches on `strobe` holds the whole word afterwards, with bit NBITS-1 in the stage farthest from its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to send `word_in` |
| word_in | input | NBITS | Parallel word to load |
| ready | output | 1 | High when a new start is accepted |
| busy | output | 1 | High while a frame is in progress |
| ser_data | output | 1 | Serial data to the driver |
| shift_clk | output | 1 | Shift clock to the driver |
| strobe | output | 1 | Latch strobe to the driver |
| blank | output | 1 | Output blanking to the driver |

## Verification
A wrong state, counter or shift value in this controller shows at the ports within a single system clock. The reason is that every output is decoded from the phase register and the shift register, and no output is delayed through a pipeline. The reference model predicts all six outputs for every cycle of each frame. A phase that is one cycle too short or too long, a bit sent out of order, or blanking released early is therefore reported in the very cycle it first differs. A second instance with all intervals at zero and the bypass variant enabled covers the rounding to one cycle and the blanking window.

// File: rtl/serial_word_loader_pkg.sv
package serial_word_loader_pkg;
   typedef enum logic [2:0] {
      PH_IDLE     = 3'd0,
      PH_SETUP    = 3'd1,
      PH_CLK_HIGH = 3'd2,
      PH_HOLD     = 3'd3,
      PH_GAP      = 3'd4,
      PH_STROBE   = 3'd5,
      PH_DONE     = 3'd6
   } phase_t;

   function automatic int at_least_one(input int v);
      return (v < 1) ? 1 : v;
   endfunction
endpackage

// File: rtl/swl_interval_timer.sv
module swl_interval_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/swl_bit_shifter.sv
module swl_bit_shifter #(
   parameter int NBITS = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [NBITS-1:0] word,
   input  logic             advance,
   output logic             msb,
   output logic             last_bit
);
   localparam int BW = (NBITS > 1) ? $clog2(NBITS) : 1;

   logic [NBITS-1:0] sh_q;
   logic [BW-1:0]    left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         left_q <= '0;
      end else if (load) begin
         sh_q   <= word;
         left_q <= BW'(NBITS - 1);
      end else if (advance) begin
         sh_q   <= sh_q << 1;
         left_q <= left_q - 1'b1;
      end
   end

   assign msb      = sh_q[NBITS-1];
   assign last_bit = (left_q == '0);
endmodule

// File: rtl/serial_word_loader.sv
module serial_word_loader
   import serial_word_loader_pkg::*;
#(
   parameter int NBITS             = 20,
   parameter int SETUP_CYC         = 2,
   parameter int HIGH_CYC          = 3,
   parameter int HOLD_CYC          = 2,
   parameter int STB_GAP_CYC       = 5,
   parameter int STB_CYC           = 3,
   parameter bit BLANK_DURING_LOAD = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NBITS-1:0] word_in,
   output logic             ready,
   output logic             busy,
   output logic             ser_data,
   output logic             shift_clk,
   output logic             strobe,
   output logic             blank
);
   localparam int SETUP_E = at_least_one(SETUP_CYC);
   localparam int HIGH_E  = at_least_one(HIGH_CYC);
   localparam int HOLD_E  = at_least_one(HOLD_CYC);
   localparam int GAP_E   = at_least_one(STB_GAP_CYC);
   localparam int STB_E   = at_least_one(STB_CYC);
   localparam int MAX_A   = (SETUP_E > HIGH_E) ? SETUP_E : HIGH_E;
   localparam int MAX_B   = (HOLD_E > GAP_E) ? HOLD_E : GAP_E;
   localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int MAX_E   = (MAX_C > STB_E) ? MAX_C : STB_E;
   localparam int CW      = $clog2(MAX_E + 1);

   localparam logic [CW-1:0] LD_SETUP = CW'(SETUP_E - 1);
   localparam logic [CW-1:0] LD_HIGH  = CW'(HIGH_E - 1);
   localparam logic [CW-1:0] LD_HOLD  = CW'(HOLD_E - 1);
   localparam logic [CW-1:0] LD_GAP   = CW'(GAP_E - 1);
   localparam logic [CW-1:0] LD_STB   = CW'(STB_E - 1);

   if (NBITS < 1) begin : g_bad_nbits
      $error("serial_word_loader: NBITS must be at least 1");
   end
   if (SETUP_CYC < 0 || HIGH_CYC < 0 || HOLD_CYC < 0 || STB_GAP_CYC < 0 || STB_CYC < 0)
   begin : g_bad_timing
      $error("serial_word_loader: interval parameters must not be negative");
   end

   phase_t        ph_q, ph_d;
   logic          tmr_load;
   logic [CW-1:0] tmr_val;
   logic          tmr_done;
   logic          sh_load, sh_adv, sh_msb, sh_last;

   swl_interval_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_done)
   );

   swl_bit_shifter #(.NBITS(NBITS)) u_shifter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sh_load),
      .word     (word_in),
      .advance  (sh_adv),
      .msb      (sh_msb),
      .last_bit (sh_last)
   );

   always_comb begin
      ph_d     = ph_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      sh_load  = 1'b0;
      sh_adv   = 1'b0;
      unique case (ph_q)
         PH_IDLE: if (start) begin
            ph_d = PH_SETUP; tmr_load = 1'b1; tmr_val = LD_SETUP; sh_load = 1'b1;
         end
         PH_SETUP: if (tmr_done) begin
            ph_d = PH_CLK_HIGH; tmr_load = 1'b1; tmr_val = LD_HIGH;
         end
         PH_CLK_HIGH: if (tmr_done) begin
            ph_d = PH_HOLD; tmr_load = 1'b1; tmr_val = LD_HOLD;
         end
         PH_HOLD: if (tmr_done) begin
            tmr_load = 1'b1;
            if (sh_last) begin
               ph_d = PH_GAP; tmr_val = LD_GAP;
            end else begin
               ph_d = PH_SETUP; tmr_val = LD_SETUP; sh_adv = 1'b1;
            end
         end
         PH_GAP: if (tmr_done) begin
            ph_d = PH_STROBE; tmr_load = 1'b1; tmr_val = LD_STB;
         end
         PH_STROBE: if (tmr_done) ph_d = PH_DONE;
         PH_DONE:   ph_d = PH_IDLE;
         default:   ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else        ph_q <= ph_d;
   end

   logic in_bit;
   assign in_bit    = (ph_q == PH_SETUP) || (ph_q == PH_CLK_HIGH) || (ph_q == PH_HOLD);
   assign ready     = (ph_q == PH_IDLE);
   assign busy      = (ph_q != PH_IDLE);
   assign ser_data  = in_bit & sh_msb;
   assign shift_clk = (ph_q == PH_CLK_HIGH);
   assign strobe    = (ph_q == PH_STROBE);

   if (BLANK_DURING_LOAD) begin : g_blank_load
      assign blank = in_bit || (ph_q == PH_GAP) || (ph_q == PH_STROBE);
   end else begin : g_blank_off
      assign blank = 1'b0;
   end
endmodule

// File: rtl/serial_word_loader_chk.sv
module serial_word_loader_chk #(
   parameter int NBITS             = 20,
   parameter int HIGH_E            = 1,
   parameter int GAP_E             = 1,
   parameter int STB_E             = 1,
   parameter bit BLANK_DURING_LOAD = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic ready,
   input logic busy,
   input logic ser_data,
   input logic shift_clk,
   input logic strobe,
   input logic blank
);
   int hi_len, low_len, stb_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_len  <= 0;
         low_len <= 0;
         stb_len <= 0;
      end else begin
         hi_len  <= shift_clk ? hi_len + 1 : 0;
         low_len <= shift_clk ? 0 : ((low_len < 1000000) ? low_len + 1 : low_len);
         stb_len <= strobe ? stb_len + 1 : 0;
      end
   end

   assert_ready_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ready != busy);
   assert_setup_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shift_clk) |-> $stable(ser_data));
   assert_high_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shift_clk) |-> (hi_len == HIGH_E));
   assert_data_while_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_clk && $past(shift_clk)) |-> $stable(ser_data));
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shift_clk) |-> $stable(ser_data));
   assert_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe) |-> (low_len >= GAP_E));
   assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(strobe && shift_clk));
   assert_strobe_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strobe) |-> (stb_len == STB_E));
   assert_strobe_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strobe) |-> busy);

   if (BLANK_DURING_LOAD) begin : g_blank_chk
      assert_blank_clk_R10: assert property (@(posedge clk) disable iff (!rst_n)
         shift_clk |-> blank);
      assert_blank_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
         strobe |-> blank);
   end else begin : g_noblank_chk
      assert_blank_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !blank);
   end
endmodule

bind serial_word_loader serial_word_loader_chk #(
   .NBITS             (NBITS),
   .HIGH_E            (HIGH_E),
   .GAP_E             (GAP_E),
   .STB_E             (STB_E),
   .BLANK_DURING_LOAD (BLANK_DURING_LOAD)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ready     (ready),
   .busy      (busy),
   .ser_data  (ser_data),
   .shift_clk (shift_clk),
   .strobe    (strobe),
   .blank     (blank)
);

// File: tb/serial_word_loader_tb_top.sv
`timescale 1ns/1ps
module serial_word_loader_tb_top;
   localparam int N = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [N-1:0] word = '0;
   int checks = 0;
   int fails = 0;

   always #10 clk = ~clk;

   logic a_rdy, a_busy, a_dat, a_sck, a_stb, a_blk;
   logic b_rdy, b_busy, b_dat, b_sck, b_stb, b_blk;

   serial_word_loader #(.NBITS(N), .SETUP_CYC(2), .HIGH_CYC(3), .HOLD_CYC(1),
      .STB_GAP_CYC(5), .STB_CYC(3), .BLANK_DURING_LOAD(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .word_in(word),
      .ready(a_rdy), .busy(a_busy), .ser_data(a_dat), .shift_clk(a_sck),
      .strobe(a_stb), .blank(a_blk));

   serial_word_loader #(.NBITS(N), .SETUP_CYC(0), .HIGH_CYC(0), .HOLD_CYC(0),
      .STB_GAP_CYC(0), .STB_CYC(0), .BLANK_DURING_LOAD(1'b1)) dut_b (
      .clk(clk), .rst_n(rst_n), .start(start), .word_in(word),
      .ready(b_rdy), .busy(b_busy), .ser_data(b_dat), .shift_clk(b_sck),
      .strobe(b_stb), .blank(b_blk));

   // Reference timing per instance: {setup, high, hold, gap, strobe, blank mode}
   int tm [2][6] = '{'{2, 3, 1, 5, 3, 0}, '{1, 1, 1, 1, 1, 1}};
   int pos [2] = '{-1, -1};
   logic [N-1:0] cur [2];

   function automatic int frame_len(input int d);
      return N * (tm[d][0] + tm[d][1] + tm[d][2]) + tm[d][3] + tm[d][4] + 1;
   endfunction

   task automatic chk(input string tag, input string what, input int d,
                      input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s dut%0d %s pos=%0d actual=%0b expected=%0b",
                  tag, d, what, pos[d], act, exp);
      end
   endtask

   // Per-cycle comparison against the behavioural frame model
   task automatic compare(input int d, input logic rdy, input logic bsy, input logic dat,
                          input logic sck, input logic stb, input logic blk);
      int p, per, b, r;
      logic e_dat, e_sck, e_stb, e_blk;
      string t_dat, t_sck, t_stb;
      p = pos[d];
      per = tm[d][0] + tm[d][1] + tm[d][2];
      e_dat = 1'b0; e_sck = 1'b0; e_stb = 1'b0; e_blk = 1'b0;
      t_dat = "R3"; t_sck = "R5"; t_stb = "R8";
      if (p < 0) begin
         chk("R1", "ready", d, rdy, 1'b1);
         chk("R2", "busy", d, bsy, 1'b0);
         t_dat = "R1"; t_sck = "R1"; t_stb = "R1";
      end else begin
         chk("R2", "ready", d, rdy, 1'b0);
         chk("R2", "busy", d, bsy, 1'b1);
         if (p < N * per) begin
            b = p / per; r = p % per;
            e_dat = cur[d][N-1-b];
            e_sck = (r >= tm[d][0]) && (r < tm[d][0] + tm[d][1]);
            e_blk = tm[d][5] != 0;
            if (r < tm[d][0]) begin t_dat = "R4"; t_sck = "R4"; end
            else if (r >= tm[d][0] + tm[d][1]) begin t_dat = "R6"; t_sck = "R6"; end
         end else if (p < N * per + tm[d][3]) begin
            e_blk = tm[d][5] != 0; t_stb = "R7";
         end else if (p < N * per + tm[d][3] + tm[d][4]) begin
            e_stb = 1'b1; e_blk = tm[d][5] != 0;
         end
      end
      if (d == 1 && p >= 0) begin t_dat = "R9"; t_sck = "R9"; t_stb = "R9"; end
      chk(t_dat, "ser_data", d, dat, e_dat);
      chk(t_sck, "shift_clk", d, sck, e_sck);
      chk(t_stb, "strobe", d, stb, e_stb);
      chk("R10", "blank", d, blk, e_blk);
   endtask

   // Model state advances on the system clock edge
   always @(posedge clk) begin
      for (int d = 0; d < 2; d++) begin
         if (!rst_n) pos[d] = -1;
         else if (pos[d] < 0) begin
            if (start) begin pos[d] = 0; cur[d] = word; end
         end else begin
            pos[d] = pos[d] + 1;
            if (pos[d] >= frame_len(d)) pos[d] = -1;
         end
      end
   end

   // Downstream driver model: shift on rising shift clock, latch while strobe high
   logic [N-1:0] sr [2] = '{'0, '0};
   logic [N-1:0] lat [2] = '{'0, '0};
   logic prev_sck [2] = '{1'b0, 1'b0};

   always @(negedge clk) begin
      if (rst_n) begin
         compare(0, a_rdy, a_busy, a_dat, a_sck, a_stb, a_blk);
         compare(1, b_rdy, b_busy, b_dat, b_sck, b_stb, b_blk);
      end
      if (a_sck && !prev_sck[0]) sr[0] = {sr[0][N-2:0], a_dat};
      if (b_sck && !prev_sck[1]) sr[1] = {sr[1][N-2:0], b_dat};
      prev_sck[0] = a_sck; prev_sck[1] = b_sck;
      if (a_stb) lat[0] = sr[0];
      if (b_stb) lat[1] = sr[1];
   end

   task automatic send(input logic [N-1:0] w, input bit poke_busy);
      @(negedge clk);
      word = w; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke_busy) begin
         repeat (7) @(negedge clk);
         word = ~w; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      word = ~w;
      while (!(a_rdy && b_rdy)) @(negedge clk);
      for (int d = 0; d < 2; d++) begin
         checks++;
         if (lat[d] !== w) begin
            fails++;
            $display("FAIL R11 dut%0d latched actual=%h expected=%h", d, lat[d], w);
         end
      end
      checks++;
      if (lat[0][N-1] !== w[N-1]) begin
         fails++;
         $display("FAIL R11 far stage actual=%b expected=%b", lat[0][N-1], w[N-1]);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      send(20'hA5A5A, 1'b0);
      send(20'h00000, 1'b0);
      send(20'hFFFFF, 1'b0);
      send(20'h80001, 1'b0);
      send(20'h12345, 1'b1);
      send(20'h0F0F0, 1'b0);
      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule